// File: doc/BRIEF.md
# Per-Pin Debounce Filter Bank

This block holds one glitch filter for each of the lowest-numbered external interrupt pins. It sits between the pin inputs and the interrupt detector. Each raw input is first synchronised. When its filter is enabled, the filtered output changes only after the synchronised input has held a new value for a whole settle period. The period is a number of ticks from a shared prescaler. A pin without a filter, or with its filter turned off, passes its synchronised input straight through one register stage.

Software reaches the filters through a small word-addressed register space. Each 32-bit word packs four pins in 8-bit lanes. The same words can be reached at three windows: a direct window that loads and reads back, a set window that ORs ones in, and a clear window that clears the ones written. Each lane holds an enable bit, a self-clearing counter reset bit and a 4-bit index into a parameter table of settle periods. Enable requests are accepted only for pins that the neighbouring detector marks as level-sensitive.

Top module: `dbf_bank`

## Requirements
- R1: After reset every lane reads zero and every pin output is low.
- R2: Pin n is controlled by the word at byte offset (n/4)*4 from a window base, in the lane at bits (n%4)*8+7 down to (n%4)*8. Inside a lane, bit 0 is enable, bit 1 is counter reset, bits 7:4 are the period index, and bits 3:2 read zero. A write at the direct window (default base 0x500) loads the lane, and a read there returns it.
- R3: A write at the set window (default 0x600) ORs the written ones into a lane. A write at the clear window (default 0x700) clears them, so 0xFF in a lane clears enable, reset and index together.
- R4: An enable request for a pin whose level_sens bit is 0 is ignored: the enable bit stays 0 and the output keeps following the input directly.
- R5: Pins with index at or above NUM_FILT have no filter: their lanes read zero whatever is written, and their outputs follow the synchronised input.
- R6: With the filter disabled, an input change shows at the output exactly three clock edges later: two synchroniser stages and one output register.
- R7: With the filter enabled, the output takes the input value only after the synchronised input has differed from the output for the selected number of ticks. Any return to the output value restarts the count.
- R8: A period index selects the table entry of that number. An index beyond the table uses the last entry.
- R9: Writing 1 to the counter reset bit through the direct or set window makes it read 1 for two clock cycles. It then clears itself. While it is set the count is held at zero and the output is loaded with the synchronised input.
- R10: The prescaler gives one sample tick every PRESC clock cycles. With PRESC ticks per count, a settle of P ticks takes between (P-1)*PRESC+1 and P*PRESC cycles after the synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register space |
| bus_addr | input | ADDR_W | Byte address, used for both reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data from the direct window at bus_addr (combinational) |
| level_sens | input | NUM_FILT | 1 marks a filtered pin as level-sensitive |
| pin_in | input | NPIN | Raw pin levels |
| pin_out | output | NPIN | Filtered levels to the interrupt detector |

## Verification
The bench bounces a filtered pin with pulses shorter than its period. A filter that kept its count across bounces would let a false edge through, and the monitor would report it as a change nobody predicted. Each predicted change has a cycle window built from the tick count, so a design that picked the wrong table entry, wrapped an index past the table end, or dropped a synchroniser stage lands outside its window. The bench also checks that the set and clear windows touch only the written bits and lane. An enable written to an edge-sensitive pin must not take hold, so that pin's next change must still pass straight through. The counter reset bit is read back on the two cycles around its self-clear, and the output must jump to the input at once.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

  // One 8-bit control lane: the positions are decoded by software.
  typedef struct packed {
    logic [3:0] idx;
    logic [1:0] rsv;
    logic       rst;
    logic       en;
  } lane_t;

  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 8;

  // Address falls on a word inside a window of nword words.
  function automatic logic in_window(input logic [31:0] a,
                                     input logic [31:0] base,
                                     input int unsigned nword);
    return (a >= base) && (a < base + 32'(nword * 4)) && (a[1:0] == 2'b00);
  endfunction

  function automatic int unsigned word_sel(input logic [31:0] a,
                                           input logic [31:0] base);
    return (a - base) >> 2;
  endfunction

  function automatic int unsigned pin_word(input int unsigned p);
    return p / LANES;
  endfunction

  function automatic int unsigned pin_shift(input int unsigned p);
    return (p % LANES) * LANE_W;
  endfunction

  // Index past the end of the table falls back to the last entry.
  function automatic int unsigned clamp_index(input int unsigned ix,
                                              input int unsigned ntab);
    return (ix >= ntab) ? ntab - 1 : ix;
  endfunction

endpackage

// File: rtl/dbf_tick.sv
module dbf_tick #(
  parameter int unsigned PRESC = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (PRESC > 1) ? $clog2(PRESC) : 1;

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == CW'(PRESC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (PRESC > 1) begin : g_spaced
      // R10: ticks never come on back-to-back cycles
      a_r10_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/dbf_regs.sv
module dbf_regs import dbf_pkg::*; #(
  parameter int unsigned NPIN      = 8,
  parameter int unsigned NUM_FILT  = 6,
  parameter int unsigned ADDR_W    = 12,
  parameter logic [31:0] CTRL_BASE = 32'h500,
  parameter logic [31:0] SET_BASE  = 32'h600,
  parameter logic [31:0] CLR_BASE  = 32'h700,
  parameter int unsigned RST_HOLD  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NUM_FILT-1:0]   level_sens,
  output logic [NUM_FILT-1:0]   en_o,
  output logic [NUM_FILT-1:0]   clr_o,
  output logic [NUM_FILT*4-1:0] idx_o
);
  localparam int unsigned NWORD  = (NPIN + LANES - 1) / LANES;
  localparam int unsigned HOLD_W = $clog2(RST_HOLD + 1);

  logic [31:0] a32;
  assign a32 = {{(32-ADDR_W){1'b0}}, bus_addr};

  logic wr_ctrl, wr_set, wr_clr;
  assign wr_ctrl = bus_wr && in_window(a32, CTRL_BASE, NWORD);
  assign wr_set  = bus_wr && in_window(a32, SET_BASE,  NWORD);
  assign wr_clr  = bus_wr && in_window(a32, CLR_BASE,  NWORD);

  logic              en_r   [NUM_FILT];
  logic [3:0]        idx_r  [NUM_FILT];
  logic [HOLD_W-1:0] hold_r [NUM_FILT];

  logic unused_bits;
  assign unused_bits = ^bus_wdata;

  generate
    for (genvar p = 0; p < NUM_FILT; p++) begin : g_lane
      localparam int unsigned WORD = pin_word(p);
      localparam int unsigned SH   = pin_shift(p);

      lane_t b;
      logic  hit_c, hit_s, hit_k;
      logic [HOLD_W-1:0] hold_dec;

      assign b        = lane_t'(bus_wdata[SH +: LANE_W]);
      assign hit_c    = wr_ctrl && (word_sel(a32, CTRL_BASE) == WORD);
      assign hit_s    = wr_set  && (word_sel(a32, SET_BASE)  == WORD);
      assign hit_k    = wr_clr  && (word_sel(a32, CLR_BASE)  == WORD);
      assign hold_dec = (hold_r[p] == '0) ? '0 : hold_r[p] - 1'b1;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          en_r[p]   <= 1'b0;
          idx_r[p]  <= '0;
          hold_r[p] <= '0;
        end else if (hit_c) begin
          en_r[p]   <= b.en ? (en_r[p] | level_sens[p]) : 1'b0;
          idx_r[p]  <= b.idx;
          hold_r[p] <= b.rst ? HOLD_W'(RST_HOLD) : hold_dec;
        end else if (hit_s) begin
          if (b.en && level_sens[p]) en_r[p] <= 1'b1;
          idx_r[p]  <= idx_r[p] | b.idx;
          hold_r[p] <= b.rst ? HOLD_W'(RST_HOLD) : hold_dec;
        end else if (hit_k) begin
          if (b.en) en_r[p] <= 1'b0;
          idx_r[p]  <= idx_r[p] & ~b.idx;
          hold_r[p] <= b.rst ? '0 : hold_dec;
        end else begin
          hold_r[p] <= hold_dec;
        end
      end

      assign en_o[p]          = en_r[p];
      assign clr_o[p]         = (hold_r[p] != '0);
      assign idx_o[p*4 +: 4]  = idx_r[p];

      // R4: enable can only turn on for a level-sensitive pin
      a_r4_enable_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_r[p]) |-> $past(level_sens[p]));

      // R9: with no new write the reset hold only counts down
      a_r9_reset_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_r[p] != '0) && !bus_wr |=> hold_r[p] < $past(hold_r[p]));
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    if (in_window(a32, CTRL_BASE, NWORD)) begin
      for (int p = 0; p < NUM_FILT; p++) begin
        if (word_sel(a32, CTRL_BASE) == pin_word(p))
          bus_rdata[pin_shift(p) +: LANE_W] =
            {idx_r[p], 2'b00, hold_r[p] != '0, en_r[p]};
      end
    end
  end
endmodule

// File: rtl/dbf_filter.sv
module dbf_filter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic             clr,
  input  logic [CNT_W-1:0] period,
  input  logic             sin,
  output logic             dout
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_nxt;
  logic             differ;
  logic             settle_hit;

  assign differ     = (sin != dout);
  assign cnt_nxt    = {1'b0, cnt_q} + 1'b1;
  assign settle_hit = en && !clr && differ && tick && (cnt_nxt >= {1'b0, period});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dout  <= 1'b0;
    end else if (!en || clr) begin
      cnt_q <= '0;
      dout  <= sin;
    end else if (!differ) begin
      cnt_q <= '0;
    end else if (settle_hit) begin
      cnt_q <= '0;
      dout  <= sin;
    end else if (tick) begin
      cnt_q <= cnt_nxt[CNT_W-1:0];
    end
  end

  // R6: a disabled filter passes the input through one stage
  a_r6_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> dout == $past(sin));

  // R9: counter reset loads the input and zeroes the count
  a_r9_reset_loads: assert property (@(posedge clk) disable iff (!rst_n)
    en && clr |=> (dout == $past(sin)) && (cnt_q == '0));

  // R7: an enabled filter moves only on a settle hit
  a_r7_hold_until_settled: assert property (@(posedge clk) disable iff (!rst_n)
    en && !clr && !settle_hit |=> dout == $past(dout));

  // R7: a bounce back to the output value restarts the count
  a_r7_bounce_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    en && !clr && !differ |=> cnt_q == '0);
endmodule

// File: rtl/dbf_bank.sv
module dbf_bank import dbf_pkg::*; #(
  parameter int unsigned NPIN      = 8,
  parameter int unsigned NUM_FILT  = 6,
  parameter int unsigned PRESC     = 4,
  parameter int unsigned NTAB      = 7,
  parameter int unsigned PERIODS [NTAB] = '{2, 3, 4, 6, 8, 12, 16},
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned ADDR_W    = 12,
  parameter logic [31:0] CTRL_BASE = 32'h500,
  parameter logic [31:0] SET_BASE  = 32'h600,
  parameter logic [31:0] CLR_BASE  = 32'h700
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_FILT-1:0] level_sens,
  input  logic [NPIN-1:0]     pin_in,
  output logic [NPIN-1:0]     pin_out
);
  logic [NPIN-1:0]       sync1_q, sync2_q;
  logic                  tick;
  logic [NUM_FILT-1:0]   en_w, clr_w;
  logic [NUM_FILT*4-1:0] idx_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  dbf_tick #(.PRESC(PRESC)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  dbf_regs #(
    .NPIN(NPIN), .NUM_FILT(NUM_FILT), .ADDR_W(ADDR_W),
    .CTRL_BASE(CTRL_BASE), .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE),
    .RST_HOLD(2)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .level_sens (level_sens),
    .en_o       (en_w),
    .clr_o      (clr_w),
    .idx_o      (idx_w)
  );

  generate
    for (genvar p = 0; p < NPIN; p++) begin : g_pin
      if (p < NUM_FILT) begin : g_filt
        int unsigned      sel;
        logic [CNT_W-1:0] period;

        assign sel    = clamp_index(int'(idx_w[p*4 +: 4]), NTAB);
        assign period = CNT_W'(PERIODS[sel]);

        dbf_filter #(.CNT_W(CNT_W)) u_filt (
          .clk    (clk),
          .rst_n  (rst_n),
          .tick   (tick),
          .en     (en_w[p]),
          .clr    (clr_w[p]),
          .period (period),
          .sin    (sync2_q[p]),
          .dout   (pin_out[p])
        );
      end else begin : g_pass
        logic pass_q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pass_q <= 1'b0;
          else        pass_q <= sync2_q[p];
        end
        assign pin_out[p] = pass_q;

        // R5: an unfiltered pin tracks its synchronised input
        a_r5_unfiltered_follows: assert property (@(posedge clk) disable iff (!rst_n)
          1'b1 |=> pin_out[p] == $past(sync2_q[p]));
      end
    end
  endgenerate
endmodule

// File: tb/tb_dbf_bank.sv
module tb_dbf_bank;
  localparam int NPIN  = 8;
  localparam int NFILT = 6;
  localparam int PRESC = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0;
  logic [11:0]       bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NFILT-1:0]  level_sens = 6'b110111;
  logic [NPIN-1:0]   pin_in = '0;
  logic [NPIN-1:0]   pin_out;

  dbf_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .level_sens(level_sens),
    .pin_in(pin_in), .pin_out(pin_out)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    pin;
    bit    val;
    int    lo;
    int    hi;
    string req;
  } ev_t;

  ev_t expq[$];
  logic [NPIN-1:0] prev_out = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_ev(input int pin, input bit val, input int lo,
                           input int hi, input string req);
    ev_t e;
    e.pin = pin; e.val = val; e.lo = lo; e.hi = hi; e.req = req;
    expq.push_back(e);
  endtask

  // Monitor: every output change must match the oldest predicted change.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int p = 0; p < NPIN; p++) begin
        if (pin_out[p] !== prev_out[p]) begin
          checks++;
          if (expq.size() == 0) begin
            fails++;
            $display("FAIL unexpected change pin %0d to %0b at cycle %0d: actual 1 expected 0 changes",
                     p, pin_out[p], cyc);
          end else begin
            ev_t e;
            e = expq.pop_front();
            if (e.pin != p || e.val != pin_out[p] || cyc < e.lo || cyc > e.hi) begin
              fails++;
              $display("FAIL %s pin %0d -> %0b at cycle %0d: expected pin %0d -> %0b in [%0d,%0d]",
                       e.req, p, pin_out[p], cyc, e.pin, e.val, e.lo, e.hi);
            end
          end
        end
      end
      prev_out = pin_out;
    end
  end

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d, output int at);
    @(negedge clk);
    at = cyc;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic read_check(input logic [11:0] a, input logic [31:0] mask,
                            input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_addr = a;
    #1;
    check((bus_rdata & mask) == exp, req, $sformatf("read 0x%0h", a),
          bus_rdata & mask, exp);
  endtask

  task automatic drive(input int pin, input bit val, output int at);
    @(negedge clk);
    at = cyc;
    pin_in[pin] = val;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && expq.size() != 0; i++) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  // Window for a filtered change of P ticks driven at cycle n.
  function automatic int win_lo(input int n, input int p);
    return n + 3 + (p - 1) * PRESC;
  endfunction
  function automatic int win_hi(input int n, input int p);
    return n + 2 + p * PRESC;
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    int n;
    int m;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    read_check(12'h500, 32'hFFFF_FFFF, 32'h0, "R1");
    read_check(12'h504, 32'hFFFF_FFFF, 32'h0, "R1");
    check(pin_out == '0, "R1", "pin_out after reset", pin_out, 0);

    // R6: disabled filter passes through in three edges
    drive(5, 1'b1, n); expect_ev(5, 1'b1, n + 3, n + 3, "R6");
    wait_idle();
    drive(5, 1'b0, n); expect_ev(5, 1'b0, n + 3, n + 3, "R6");
    wait_idle();

    // R2: load lanes directly; pin0 idx6, pin1 idx1, pin2 idx15, all enabled
    bus_write(12'h500, 32'h00F1_1161, m);
    read_check(12'h500, 32'hFFFF_FFFF, 32'h00F1_1161, "R2");
    // R5: pin6 lane written but has no filter; pin4 idx2 enabled
    bus_write(12'h504, 32'h0011_0021, m);
    read_check(12'h504, 32'hFFFF_FFFF, 32'h0000_0021, "R5");

    // R4: enable via set window on edge-sensitive pin3 is ignored
    bus_write(12'h600, 32'h0100_0000, m);
    read_check(12'h500, 32'hFFFF_FFFF, 32'h00F1_1161, "R4");
    drive(3, 1'b1, n); expect_ev(3, 1'b1, n + 3, n + 3, "R4");
    wait_idle();
    drive(3, 1'b0, n); expect_ev(3, 1'b0, n + 3, n + 3, "R4");
    wait_idle();

    // R7: bounces shorter than 3 ticks must not pass
    for (int k = 0; k < 3; k++) begin
      drive(1, 1'b1, n); repeat (4) @(negedge clk);
      drive(1, 1'b0, n); repeat (4) @(negedge clk);
    end
    repeat (20) @(negedge clk);
    check(pin_out[1] == 1'b0, "R7", "pin1 after bounce", pin_out[1], 0);
    drive(1, 1'b1, n); expect_ev(1, 1'b1, win_lo(n, 3), win_hi(n, 3), "R7");
    wait_idle();

    // R8: index 15 is past the table and takes the last entry (16 ticks)
    drive(2, 1'b1, n); expect_ev(2, 1'b1, win_lo(n, 16), win_hi(n, 16), "R8");
    wait_idle();
    // R10: pin4 index 2 is 4 ticks of PRESC cycles each
    drive(4, 1'b1, n); expect_ev(4, 1'b1, win_lo(n, 4), win_hi(n, 4), "R10");
    wait_idle();

    // R3: clearing pin1 lane with 0xFF disables it
    bus_write(12'h700, 32'h0000_FF00, m);
    read_check(12'h500, 32'hFFFF_FFFF, 32'h00F1_0061, "R3");
    drive(1, 1'b0, n); expect_ev(1, 1'b0, n + 3, n + 3, "R3");
    wait_idle();
    // R3: set window ORs only the written index bit
    bus_write(12'h600, 32'h0000_2000, m);
    read_check(12'h500, 32'hFFFF_FFFF, 32'h00F1_2061, "R3");

    // R9: counter reset loads the input and clears itself after two cycles
    drive(0, 1'b1, n);
    repeat (10) @(negedge clk);
    bus_write(12'h600, 32'h0000_0002, m);
    expect_ev(0, 1'b1, m + 2, m + 2, "R9");
    read_check(12'h500, 32'h0000_00FF, 32'h0000_0063, "R9");
    read_check(12'h500, 32'h0000_00FF, 32'h0000_0061, "R9");
    wait_idle();

    // R5: unfiltered pins follow their input
    drive(6, 1'b1, n); expect_ev(6, 1'b1, n + 3, n + 3, "R5");
    wait_idle();
    drive(7, 1'b1, n); expect_ev(7, 1'b1, n + 3, n + 3, "R5");
    wait_idle();

    repeat (80) @(negedge clk);
    check(expq.size() == 0, "R7", "predicted changes left", expq.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule